// File: doc/BRIEF.md
# Sixteen-bit ALU with Arithmetic Status Flags

This block is the arithmetic and logic unit of a small 16-bit controller datapath. It is combinational from operands to result. It takes a source operand, a destination operand, a four-bit operation code and a byte/word select. It returns the result, a destination write-enable and the next values of the four arithmetic flags: carry, zero, negative and overflow. Beside it sits a registered status word. The flag part of that word loads the next flag values when the update strobe is high. The current carry feeds back into the rotate, add-with-carry and subtract-with-carry operations.

Five system-control bits are not touched by any operation. They come in on their own input and appear unchanged in the status word. There is no sequencing state. The only storage is the flag register, which has two conditions: hold (update strobe low) and load (update strobe high). Operand fetch, addressing and instruction decode are handled outside the block.

Top module: `alu16_flagged`

## Requirements
- R1: While reset is low, and on the first cycle after it, the four stored flags read zero in the status word.
- R2: Status word layout: carry at bit 0, zero at bit 1, negative at bit 2, overflow at bit 8. The system-control input bits 0..4 appear unchanged at status bits 3..7. All other bits are zero.
- R3: The negative flag equals result bit 15 in word mode and bit 7 in byte mode. The zero flag is set when the result is zero. Outside sign extend, byte mode ignores operand bits 15..8 and drives result bits 15..8 to zero.
- R4: Add (code 3) gives dst+src. Add-with-carry (code 4) gives dst+src+C. The next carry is the carry out of bit 15 (word) or bit 7 (byte).
- R5: Subtract (code 6) gives dst+~src+1. Subtract-with-carry (code 5) gives dst+~src+C. Carry is the carry out, so it is 1 when no borrow occurs.
- R6: For codes 3..7, overflow is set when dst and the effective source (inverted for codes 5..7) share a sign and the result sign differs from dst's.
- R7: Compare (code 7) computes and flags exactly like subtract. Compare and bit test (code 8) hold write-enable low. Codes 0..6, 9 and 10 raise write-enable.
- R8: Rotate through carry (code 0) puts the old C in the top bit (15 or 7), shifts right by one, moves operand bit 0 into C and clears overflow.
- R9: Arithmetic shift right (code 1) keeps the sign bit (15 or 7), moves operand bit 0 into C and clears overflow.
- R10: Sign extend (code 2) copies bit 7 into bits 15..8 whatever the byte select. Negative follows bit 15. C is set when the result is nonzero. Overflow is cleared.
- R11: AND (code 10) and bit test (code 8) give src&dst. XOR (code 9) gives src^dst. For all three, C is set when the result is nonzero. Overflow is cleared, except that XOR sets it when both operands' sign bits are 1.
- R12: The flag register loads the next flags on a clock edge only when the update strobe is high. Otherwise it holds.
- R13: Codes 11..15 give a zero result and write-enable low, and their next flags equal the stored flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte mode, 0 selects word mode |
| upd_i | input | 1 | Flag register load strobe |
| sys_i | input | 5 | System-control bits shown in the status word |
| res_o | output | 16 | Result |
| wr_en_o | output | 1 | Destination write-enable |
| c_nxt_o | output | 1 | Next carry |
| z_nxt_o | output | 1 | Next zero |
| n_nxt_o | output | 1 | Next negative |
| v_nxt_o | output | 1 | Next overflow |
| status_o | output | 16 | Status word |

## Verification
Two things can happen in the same cycle: the flag register loading, and a carry-consuming operation (add-with-carry, subtract-with-carry, rotate) reading carry. The bench provokes this with back-to-back multi-word add-with-carry and subtract-with-carry steps that keep the update strobe high. Each step must use the carry left by the step before it, never the one it is about to produce. An independent flag model in the bench is advanced only on strobed steps. It is compared with every result and with the status word observed one edge later.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_RRC  = 4'd0,
        OP_RRA  = 4'd1,
        OP_SXT  = 4'd2,
        OP_ADD  = 4'd3,
        OP_ADDC = 4'd4,
        OP_SUBC = 4'd5,
        OP_SUB  = 4'd6,
        OP_CMP  = 4'd7,
        OP_BIT  = 4'd8,
        OP_XOR  = 4'd9,
        OP_AND  = 4'd10
    } alu_op_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    localparam int ST_C      = 0;
    localparam int ST_Z      = 1;
    localparam int ST_N      = 2;
    localparam int ST_SYS_LO = 3;
    localparam int SYS_W     = 5;
    localparam int ST_V      = 8;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op_i,
    input  logic           byte_i,
    input  logic [W-1:0]   src_i,
    input  logic [W-1:0]   dst_i,
    input  logic           cin_i,
    output logic [W-1:0]   res_o,
    output logic           c_o,
    output logic           v_o
);
    localparam int H = W / 2;

    logic [W-1:0] s_eff;
    logic         ci;
    logic [W:0]   sum_w;
    logic [H:0]   sum_b;
    logic         sd, ss, sr;

    always_comb begin
        unique case (op_i)
            OP_ADD:          begin s_eff = src_i;  ci = 1'b0;  end
            OP_ADDC:         begin s_eff = src_i;  ci = cin_i; end
            OP_SUBC:         begin s_eff = ~src_i; ci = cin_i; end
            OP_SUB, OP_CMP:  begin s_eff = ~src_i; ci = 1'b1;  end
            default:         begin s_eff = src_i;  ci = 1'b0;  end
        endcase
    end

    assign sum_w = {1'b0, dst_i} + {1'b0, s_eff} + {{W{1'b0}}, ci};
    assign sum_b = {1'b0, dst_i[H-1:0]} + {1'b0, s_eff[H-1:0]} + {{H{1'b0}}, ci};

    always_comb begin
        if (byte_i) begin
            res_o = {{(W-H){1'b0}}, sum_b[H-1:0]};
            c_o   = sum_b[H];
            sd    = dst_i[H-1];
            ss    = s_eff[H-1];
            sr    = sum_b[H-1];
        end else begin
            res_o = sum_w[W-1:0];
            c_o   = sum_w[W];
            sd    = dst_i[W-1];
            ss    = s_eff[W-1];
            sr    = sum_w[W-1];
        end
        v_o = (sd == ss) && (sr != sd);
    end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op_i,
    input  logic           byte_i,
    input  logic [W-1:0]   src_i,
    input  logic           cin_i,
    output logic [W-1:0]   res_o,
    output logic           c_o
);
    localparam int H = W / 2;

    logic fill;

    always_comb begin
        if (op_i == OP_RRC) fill = cin_i;
        else                fill = byte_i ? src_i[H-1] : src_i[W-1];

        if (op_i == OP_SXT) begin
            res_o = {{(W-H){src_i[H-1]}}, src_i[H-1:0]};
            c_o   = |src_i[H-1:0];
        end else if (byte_i) begin
            res_o = {{(W-H){1'b0}}, fill, src_i[H-1:1]};
            c_o   = src_i[0];
        end else begin
            res_o = {fill, src_i[W-1:1]};
            c_o   = src_i[0];
        end
    end

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op_i,
    input  logic           byte_i,
    input  logic [W-1:0]   src_i,
    input  logic [W-1:0]   dst_i,
    output logic [W-1:0]   res_o,
    output logic           c_o,
    output logic           v_o
);
    localparam int H = W / 2;

    logic [W-1:0] raw;
    logic [W-1:0] mask;
    logic         both_neg;

    always_comb begin
        raw      = (op_i == OP_XOR) ? (src_i ^ dst_i) : (src_i & dst_i);
        mask     = byte_i ? {{(W-H){1'b0}}, {H{1'b1}}} : {W{1'b1}};
        res_o    = raw & mask;
        c_o      = |res_o;
        both_neg = byte_i ? (src_i[H-1] & dst_i[H-1]) : (src_i[W-1] & dst_i[W-1]);
        v_o      = (op_i == OP_XOR) && both_neg;
    end

endmodule

// File: rtl/alu16_flagged.sv
module alu16_flagged
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       src_i,
    input  logic [W-1:0]       dst_i,
    input  logic [3:0]         op_i,
    input  logic               byte_i,
    input  logic               upd_i,
    input  logic [SYS_W-1:0]   sys_i,
    output logic [W-1:0]       res_o,
    output logic               wr_en_o,
    output logic               c_nxt_o,
    output logic               z_nxt_o,
    output logic               n_nxt_o,
    output logic               v_nxt_o,
    output logic [W-1:0]       status_o
);
    localparam int H = W / 2;

    alu_op_e      op;
    flags_t       flag_q;
    flags_t       nxt;
    logic [W-1:0] as_res, sh_res, lg_res;
    logic         as_c, as_v, sh_c, lg_c, lg_v;

    assign op = alu_op_e'(op_i);

    alu16_addsub #(.W(W)) u_addsub (
        .op_i(op), .byte_i(byte_i), .src_i(src_i), .dst_i(dst_i),
        .cin_i(flag_q.c), .res_o(as_res), .c_o(as_c), .v_o(as_v)
    );

    alu16_shift #(.W(W)) u_shift (
        .op_i(op), .byte_i(byte_i), .src_i(src_i),
        .cin_i(flag_q.c), .res_o(sh_res), .c_o(sh_c)
    );

    alu16_logic #(.W(W)) u_logic (
        .op_i(op), .byte_i(byte_i), .src_i(src_i), .dst_i(dst_i),
        .res_o(lg_res), .c_o(lg_c), .v_o(lg_v)
    );

    // result / flag selection
    always_comb begin
        nxt     = flag_q;
        res_o   = '0;
        wr_en_o = 1'b0;
        unique case (op)
            OP_RRC, OP_RRA, OP_SXT: begin
                res_o   = sh_res;
                nxt.c   = sh_c;
                nxt.v   = 1'b0;
                wr_en_o = 1'b1;
            end
            OP_ADD, OP_ADDC, OP_SUBC, OP_SUB, OP_CMP: begin
                res_o   = as_res;
                nxt.c   = as_c;
                nxt.v   = as_v;
                wr_en_o = (op != OP_CMP);
            end
            OP_BIT, OP_XOR, OP_AND: begin
                res_o   = lg_res;
                nxt.c   = lg_c;
                nxt.v   = lg_v;
                wr_en_o = (op != OP_BIT);
            end
            default: begin
                res_o   = '0;
                wr_en_o = 1'b0;
            end
        endcase
        if (op_i <= 4'(OP_AND)) begin
            nxt.z = (res_o == '0);
            nxt.n = (byte_i && op != OP_SXT) ? res_o[H-1] : res_o[W-1];
        end
    end

    assign c_nxt_o = nxt.c;
    assign z_nxt_o = nxt.z;
    assign n_nxt_o = nxt.n;
    assign v_nxt_o = nxt.v;

    // flag register: hold or load
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= '0;
        else if (upd_i) flag_q <= nxt;
    end

    always_comb begin
        status_o                      = '0;
        status_o[ST_C]                = flag_q.c;
        status_o[ST_Z]                = flag_q.z;
        status_o[ST_N]                = flag_q.n;
        status_o[ST_V]                = flag_q.v;
        status_o[ST_SYS_LO +: SYS_W]  = sys_i;
    end

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(flag_q));

    a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> (flag_q == $past(nxt)));

    a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(OP_CMP) || op_i == 4'(OP_BIT)) |-> !wr_en_o);

    a_r5_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(OP_SUB) && !byte_i && dst_i >= src_i) |-> c_nxt_o);

    a_r3_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_i && op_i != 4'(OP_SXT)) |-> (res_o[W-1:H] == '0));

    a_r9_keep_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(OP_RRA) && !byte_i) |-> (res_o[W-1] == src_i[W-1]));

    a_r13_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'(OP_AND)) |-> (!wr_en_o && c_nxt_o == status_o[ST_C]
                                 && v_nxt_o == status_o[ST_V]));

endmodule

// File: tb/alu16_flagged_test.sv
module alu16_flagged_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] src, dst;
    logic [3:0]  op;
    logic        byt, upd;
    logic [4:0]  sys;
    logic [15:0] res, status;
    logic        we, cn, zn, nn, vn;

    int checks = 0;
    int errors = 0;
    logic [3:0] mf = 4'b0;  // model flags {v,n,z,c}

    always #10 clk = ~clk;

    alu16_flagged uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .dst_i(dst), .op_i(op),
        .byte_i(byt), .upd_i(upd), .sys_i(sys), .res_o(res), .wr_en_o(we),
        .c_nxt_o(cn), .z_nxt_o(zn), .n_nxt_o(nn), .v_nxt_o(vn), .status_o(status)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(logic [3:0] o);
        case (o)
            4'd0: return "R8";
            4'd1: return "R9";
            4'd2: return "R10";
            4'd3, 4'd4: return "R4";
            4'd5, 4'd6: return "R5";
            4'd7: return "R7";
            4'd8, 4'd9, 4'd10: return "R11";
            default: return "R13";
        endcase
    endfunction

    // returns {we, v, n, z, c, res}
    function automatic logic [20:0] model(logic [3:0] o, logic b, logic [15:0] s,
                                          logic [15:0] d, logic [3:0] f);
        logic [15:0] r, se;
        logic c, v, n, z, w, ci;
        logic [16:0] sum;
        int sb;
        sb = b ? 7 : 15;
        w = 1'b1; c = 1'b0; v = 1'b0; r = 16'h0;
        case (o)
            4'd0: begin r = b ? {8'h0, f[0], s[7:1]} : {f[0], s[15:1]}; c = s[0]; end
            4'd1: begin r = b ? {8'h0, s[7], s[7:1]} : {s[15], s[15:1]}; c = s[0]; end
            4'd2: begin r = {{8{s[7]}}, s[7:0]}; c = (r != 0); end
            4'd3, 4'd4, 4'd5, 4'd6, 4'd7: begin
                se = (o >= 4'd5) ? ~s : s;
                ci = (o == 4'd3) ? 1'b0 : (o >= 4'd6) ? 1'b1 : f[0];
                if (b) sum = {9'h0, d[7:0]} + {9'h0, se[7:0]} + {16'h0, ci};
                else   sum = {1'b0, d} + {1'b0, se} + {16'h0, ci};
                c = b ? sum[8] : sum[16];
                r = b ? {8'h0, sum[7:0]} : sum[15:0];
                v = (d[sb] == se[sb]) && (r[sb] != d[sb]);
                w = (o != 4'd7);
            end
            4'd8, 4'd10: begin
                r = s & d; if (b) r[15:8] = 8'h0; c = (r != 0); w = (o != 4'd8);
            end
            4'd9: begin
                r = s ^ d; if (b) r[15:8] = 8'h0; c = (r != 0); v = s[sb] & d[sb];
            end
            default: ;
        endcase
        if (o > 4'd10) return {1'b0, f, 16'h0};
        n = (o == 4'd2) ? r[15] : r[sb];
        z = (r == 0);
        return {w, v, n, z, c, r};
    endfunction

    task automatic step(string tag, logic [3:0] o, logic b, logic [15:0] s,
                        logic [15:0] d, logic u);
        logic [20:0] e;
        @(negedge clk);
        op = o; byt = b; src = s; dst = d; upd = u;
        #2;
        chk({tag, " R12 status flags"}, {status[8], status[2:0]}, mf);
        e = model(o, b, s, d, mf);
        chk({tag, " ", tag_of(o), " result"}, res, e[15:0]);
        chk({tag, " R7 write-enable"}, we, e[20]);
        chk({tag, " ", tag_of(o), " flags {v,n,z,c}"}, {vn, nn, zn, cn}, e[19:16]);
        chk({tag, " R3 N/Z"}, {nn, zn}, e[18:17]);
        if (u) mf = e[19:16];
    endtask

    task automatic lit(string tag, logic [15:0] r, logic [3:0] f);
        chk({tag, " literal result"}, res, r);
        chk({tag, " literal flags {v,n,z,c}"}, {vn, nn, zn, cn}, f);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; sys = 5'b10110; op = 4'd3; byt = 1'b0;
        src = 16'hFFFF; dst = 16'h0001; upd = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 flags in reset", {status[8], status[2:0]}, 4'b0);
        @(negedge clk); rst_n = 1'b1; upd = 1'b0;
        #2;
        chk("R1 flags after reset", {status[8], status[2:0]}, 4'b0);
        chk("R2 status layout", status, 16'h00B0);
    endtask

    task automatic t_sys();
        @(negedge clk); sys = 5'b01001; #2;
        chk("R2 system bits pass through", status[7:3], 5'b01001);
        chk("R2 unused bits zero", {status[15:9]}, 7'h0);
    endtask

    task automatic t_add();
        step("add ovf", 4'd3, 1'b0, 16'h0001, 16'h7FFF, 1'b0);
        lit("R6 add overflow", 16'h8000, 4'b1100);
        step("add byte", 4'd3, 1'b1, 16'hAB01, 16'h12FF, 1'b0);
        lit("R4 byte carry", 16'h0000, 4'b0011);
        step("add word carry", 4'd3, 1'b0, 16'h8000, 16'h8000, 1'b0);
        lit("R6 neg+neg overflow", 16'h0000, 4'b1011);
    endtask

    task automatic t_sub();
        step("sub eq", 4'd6, 1'b0, 16'h0005, 16'h0005, 1'b1);
        lit("R5 equal no borrow", 16'h0000, 4'b0011);
        step("sub borrow", 4'd6, 1'b0, 16'h0001, 16'h0000, 1'b0);
        lit("R5 borrow", 16'hFFFF, 4'b0100);
        step("cmp", 4'd7, 1'b0, 16'h0001, 16'h0000, 1'b0);
        lit("R7 compare as subtract", 16'hFFFF, 4'b0100);
        chk("R7 compare no write", we, 1'b0);
    endtask

    task automatic t_shift();
        // carry is 1 from the strobed equal subtract
        step("rrc", 4'd0, 1'b0, 16'h0002, 16'h0, 1'b0);
        lit("R8 rotate old carry in", 16'h8001, 4'b0100);
        step("rrc byte", 4'd0, 1'b1, 16'hFF03, 16'h0, 1'b0);
        lit("R8 byte rotate", 16'h0081, 4'b0101);
        step("rra", 4'd1, 1'b0, 16'h8003, 16'h0, 1'b0);
        lit("R9 keep sign", 16'hC001, 4'b0101);
        step("sxt", 4'd2, 1'b1, 16'h1280, 16'h0, 1'b0);
        lit("R10 sign extend", 16'hFF80, 4'b0101);
        step("sxt zero", 4'd2, 1'b0, 16'hAB00, 16'h0, 1'b0);
        lit("R10 zero result", 16'h0000, 4'b0010);
    endtask

    task automatic t_logic();
        step("xor", 4'd9, 1'b0, 16'h8000, 16'h8001, 1'b0);
        lit("R11 xor both negative", 16'h0001, 4'b1001);
        step("bit", 4'd8, 1'b0, 16'h00F0, 16'h000F, 1'b0);
        lit("R11 bit test zero", 16'h0000, 4'b0010);
        chk("R7 bit test no write", we, 1'b0);
        step("and byte", 4'd10, 1'b1, 16'hFF81, 16'hFF80, 1'b0);
        lit("R11 and byte", 16'h0080, 4'b0101);
    endtask

    task automatic t_chain();
        // flag load and carry use in the same cycles
        step("chain lo", 4'd3, 1'b0, 16'h0001, 16'hFFFF, 1'b1);
        step("chain hi", 4'd4, 1'b0, 16'h0000, 16'h0000, 1'b1);
        lit("R4 addc uses loaded carry", 16'h0001, 4'b0000);
        step("chain subc", 4'd5, 1'b0, 16'h0000, 16'h0000, 1'b1);
        lit("R5 subc with carry 0", 16'hFFFF, 4'b0100);
        step("chain probe", 4'd13, 1'b0, 16'h0, 16'h0, 1'b0);
        chk("R12 loaded flags", {status[8], status[2:0]}, 4'b0100);
    endtask

    task automatic t_idle();
        step("set flags", 4'd9, 1'b0, 16'h8000, 16'h8001, 1'b1);
        step("idle 11", 4'd11, 1'b0, 16'h1234, 16'h5678, 1'b1);
        lit("R13 idle keeps flags", 16'h0000, 4'b1001);
        chk("R13 idle no write", we, 1'b0);
        step("idle 15", 4'd15, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0);
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 24; k++) begin
            for (int o = 0; o < 16; o++) begin
                step("sweep", 4'(o), 1'(k & 1), 16'(k * 16'h3B71 + o * 16'h1D05),
                     16'(k * 16'h8123 ^ o * 16'h0F0F), 1'((k + o) % 3 == 0));
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_sys();
        t_add();
        t_sub();
        t_shift();
        t_logic();
        t_chain();
        t_idle();
        t_sweep();
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule